// File: doc/BRIEF.md
# Periodic Schedule Walker

The block follows a schedule of linked records in system memory, starting once per frame. Each frame tick makes it read one entry of a frame table. The entry's index comes from the low bits of an 11-bit frame counter, and the table sits at an aligned base address. From that entry the block chases link words. A link word can name a queue head, which is a two-word record holding a next-queue link and a first-member link. A link word can also name a transfer record, whose first word is a link and whose second word holds control and status.

A live transfer record is offered to an external transaction executor through a request/done handshake. The executor returns four error flags and a byte count. The walker then writes the updated status word back into the record. When the record was taken from a queue and finished cleanly, the walker moves that queue forward: it copies the record's link word into the queue head's member slot. A bit in each record chooses how the walk continues after a clean finish. Depth-first stays inside the queue; breadth-first moves on to the next queue. All memory traffic uses one 32-bit word port that holds each request until it is acknowledged.

Top module: `sched_walker`

## Requirements
- R1: While reset is asserted and after it is released, frame_num is 0 and neither mem_req nor exec_req is asserted until a frame tick arrives.
- R2: A frame tick seen while idle increments frame_num by one in the next cycle, wrapping from 0x7FF to 0. The first memory access of that walk is a read at {list_base[31:12], old frame_num[9:0], 2'b00}.
- R3: A link word carries the record address in bits [31:4]. Bit 1 set means a queue head and bit 1 clear means a transfer record. Bit 0 set means no record, so a terminating frame-table entry ends the walk after that single read.
- R4: A queue head is read as its next-queue link at its address and its member link at address+4. When the member link has bit 0 set, the queue is empty and the walk continues along the next-queue link.
- R5: A transfer record's status word is at address+4, and bit 23 of that word marks it live. A record with bit 23 clear is never offered to the executor.
- R6: For a live record, exec_req holds the record address. After exec_done, the status word is written back with bit 23 cleared, bits 22/19/18/17 set equal to exec_flags[3]/[2]/[1]/[0], bits [10:0] set to exec_len, and all other bits kept.
- R7: When a record taken from a queue returns all four flags clear, its link word is written to the queue head's address+4. When any flag is set, nothing is written there.
- R8: In a queue, a clean finish with record link bit 2 set (depth-first) continues at the record's own link. A clean finish with bit 2 clear, any error, or a record that is not live continues at the cached queue head's next-queue link. Reaching a terminating link inside a queue also continues at that next-queue link.
- R9: A transfer record reached outside any queue is followed by its own link whatever the returned flags.
- R10: A tick that arrives during a walk lets the ongoing access, execution and write-backs finish. The next element is then not fetched, and the walk of the following frame starts instead.
- R11: A walk fetches at most MAX_ELEMS records (queue heads and transfer records) and then stops, so a looped schedule cannot run forever.
- R12: mem_req and exec_req are never asserted together, and each holds its address and data steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle pulse at the start of each frame |
| list_base | input | 32 | Frame table base address, 4 KiB aligned |
| frame_num | output | 11 | Number of the next frame to be walked |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| exec_req | output | 1 | Transaction execution request |
| exec_td_addr | output | 32 | Address of the record to execute |
| exec_done | input | 1 | Execution complete |
| exec_flags | input | 4 | {stalled, nak, crc/timeout, bit-stuff} error flags |
| exec_len | input | 11 | Actual byte count returned |

## Verification
Corrupt internal state shows up at the ports within one walk, and always before the next tick. A stale queue-head cache writes the advanced link to the wrong address or follows the wrong next-queue link, so the executor sees records in the wrong order. A broken advance decision leaves the member slot with a wrong value right after the status write. A miscounted frame index shows on the very first read address after a tick. A fault in the loop guard or the tick-abort logic changes the exact number of memory accesses in that frame.

// File: rtl/sw_pkg.sv
package sw_pkg;
    // link word layout
    localparam int LINK_END_BIT   = 0;
    localparam int LINK_QH_BIT    = 1;
    localparam int LINK_DEPTH_BIT = 2;
    localparam int LINK_ADDR_LSB  = 4;

    // status word layout
    localparam int STAT_LIVE_BIT  = 23;
    localparam int STAT_STALL_BIT = 22;
    localparam int STAT_NAK_BIT   = 19;
    localparam int STAT_CRC_BIT   = 18;
    localparam int STAT_STUFF_BIT = 17;
    localparam int LEN_W          = 11;
    localparam int FLAG_W         = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_FL,
        ST_LINK,
        ST_RD_QH0,
        ST_RD_QH1,
        ST_RD_TD0,
        ST_RD_TD1,
        ST_EXEC,
        ST_WR_TD,
        ST_WR_QH,
        ST_AFTER
    } walk_st_e;
endpackage

// File: rtl/sw_link_dec.sv
module sw_link_dec
    import sw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] link_word,
    output logic [W-1:0] elem_addr,
    output logic         is_qh,
    output logic         is_end,
    output logic         depth_first
);
    logic unused_rsvd;

    assign elem_addr   = {link_word[W-1:LINK_ADDR_LSB], {LINK_ADDR_LSB{1'b0}}};
    assign is_qh       = link_word[LINK_QH_BIT];
    assign is_end      = link_word[LINK_END_BIT];
    assign depth_first = link_word[LINK_DEPTH_BIT];
    assign unused_rsvd = link_word[3];
endmodule

// File: rtl/sw_stat_merge.sv
module sw_stat_merge
    import sw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      old_word,
    input  logic [FLAG_W-1:0] flags,
    input  logic [LEN_W-1:0]  act_len,
    output logic [W-1:0]      new_word
);
    localparam int FLAG_POS [FLAG_W] = '{STAT_STUFF_BIT, STAT_CRC_BIT, STAT_NAK_BIT, STAT_STALL_BIT};

    always_comb begin
        new_word = old_word;
        new_word[STAT_LIVE_BIT] = 1'b0;
        for (int i = 0; i < FLAG_W; i++) begin
            new_word[FLAG_POS[i]] = flags[i];
        end
        new_word[LEN_W-1:0] = act_len;
    end
endmodule

// File: rtl/sw_frame_ctr.sv
module sw_frame_ctr #(
    parameter int FN_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            start,
    output logic [FN_W-1:0] frame_num,
    output logic            tick_any
);
    logic [FN_W-1:0] fn_d, fn_q;
    logic            pend_d, pend_q;

    assign tick_any  = tick | pend_q;
    assign frame_num = fn_q;

    always_comb begin
        fn_d   = fn_q;
        pend_d = pend_q | tick;
        if (start) begin
            fn_d   = fn_q + FN_W'(1);
            pend_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fn_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            fn_q   <= fn_d;
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/sched_walker.sv
module sched_walker
    import sw_pkg::*;
#(
    parameter int W          = 32,
    parameter int FN_W       = 11,
    parameter int FL_ENTRIES = 1024,
    parameter int MAX_ELEMS  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_tick,
    input  logic [W-1:0]      list_base,
    output logic [FN_W-1:0]   frame_num,
    output logic              mem_req,
    output logic              mem_we,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    input  logic              mem_ack,
    input  logic [W-1:0]      mem_rdata,
    output logic              exec_req,
    output logic [W-1:0]      exec_td_addr,
    input  logic              exec_done,
    input  logic [FLAG_W-1:0] exec_flags,
    input  logic [LEN_W-1:0]  exec_len
);
    localparam int         IDX_W     = $clog2(FL_ENTRIES);
    localparam int         CNT_W     = $clog2(MAX_ELEMS + 1);
    localparam logic [W-1:0] WORD_OFS = W'(W / 8);

    typedef struct packed {
        walk_st_e          st;
        logic [W-1:0]      link;
        logic              ctx;
        logic [W-1:0]      qh_addr;
        logic [W-1:0]      qh_horiz;
        logic [W-1:0]      td_addr;
        logic [W-1:0]      td_link;
        logic [W-1:0]      td_word2;
        logic [FLAG_W-1:0] flags;
        logic [LEN_W-1:0]  len;
        logic [CNT_W-1:0]  cnt;
        logic [W-1:0]      fl_addr;
    } walk_t;

    walk_t d, q;

    logic         tick_any;
    logic         walk_start;
    logic [W-1:0] cur_addr;
    logic         cur_qh, cur_end;
    logic         unused_cur_depth;
    logic         td_depth;
    logic [W-1:0] unused_td_addr;
    logic         unused_td_qh, unused_td_end;
    logic [W-1:0] merged_word;
    logic [W-1:0] fl_entry_addr;
    logic         exec_ok;
    logic         unused_base;

    sw_frame_ctr #(.FN_W(FN_W)) u_fctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (frame_tick),
        .start     (walk_start),
        .frame_num (frame_num),
        .tick_any  (tick_any)
    );

    sw_link_dec #(.W(W)) u_cur_dec (
        .link_word   (q.link),
        .elem_addr   (cur_addr),
        .is_qh       (cur_qh),
        .is_end      (cur_end),
        .depth_first (unused_cur_depth)
    );

    sw_link_dec #(.W(W)) u_td_dec (
        .link_word   (q.td_link),
        .elem_addr   (unused_td_addr),
        .is_qh       (unused_td_qh),
        .is_end      (unused_td_end),
        .depth_first (td_depth)
    );

    sw_stat_merge #(.W(W)) u_merge (
        .old_word (q.td_word2),
        .flags    (q.flags),
        .act_len  (q.len),
        .new_word (merged_word)
    );

    assign fl_entry_addr = {list_base[W-1:IDX_W+2], frame_num[IDX_W-1:0], 2'b00};
    assign unused_base   = ^list_base[IDX_W+1:0];
    assign exec_ok       = (q.flags == '0);

    // next-state logic
    always_comb begin
        d          = q;
        walk_start = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (tick_any) begin
                    walk_start = 1'b1;
                    d.st       = ST_RD_FL;
                    d.fl_addr  = fl_entry_addr;
                    d.ctx      = 1'b0;
                    d.cnt      = '0;
                end
            end
            ST_RD_FL: begin
                if (mem_ack) begin
                    d.link = mem_rdata;
                    d.st   = ST_LINK;
                end
            end
            ST_LINK: begin
                if (tick_any) begin
                    walk_start = 1'b1;
                    d.st       = ST_RD_FL;
                    d.fl_addr  = fl_entry_addr;
                    d.ctx      = 1'b0;
                    d.cnt      = '0;
                end else if (cur_end) begin
                    if (q.ctx) begin
                        d.link = q.qh_horiz;
                        d.ctx  = 1'b0;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else if (q.cnt == CNT_W'(MAX_ELEMS)) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                    if (cur_qh) begin
                        d.qh_addr = cur_addr;
                        d.st      = ST_RD_QH0;
                    end else begin
                        d.td_addr = cur_addr;
                        d.st      = ST_RD_TD0;
                    end
                end
            end
            ST_RD_QH0: begin
                if (mem_ack) begin
                    d.qh_horiz = mem_rdata;
                    d.st       = ST_RD_QH1;
                end
            end
            ST_RD_QH1: begin
                if (mem_ack) begin
                    d.link = mem_rdata;
                    d.ctx  = 1'b1;
                    d.st   = ST_LINK;
                end
            end
            ST_RD_TD0: begin
                if (mem_ack) begin
                    d.td_link = mem_rdata;
                    d.st      = ST_RD_TD1;
                end
            end
            ST_RD_TD1: begin
                if (mem_ack) begin
                    d.td_word2 = mem_rdata;
                    if (mem_rdata[STAT_LIVE_BIT]) begin
                        d.st = ST_EXEC;
                    end else if (q.ctx) begin
                        d.link = q.qh_horiz;
                        d.ctx  = 1'b0;
                        d.st   = ST_LINK;
                    end else begin
                        d.link = q.td_link;
                        d.st   = ST_LINK;
                    end
                end
            end
            ST_EXEC: begin
                if (exec_done) begin
                    d.flags = exec_flags;
                    d.len   = exec_len;
                    d.st    = ST_WR_TD;
                end
            end
            ST_WR_TD: begin
                if (mem_ack) begin
                    d.st = (q.ctx && exec_ok) ? ST_WR_QH : ST_AFTER;
                end
            end
            ST_WR_QH: begin
                if (mem_ack) begin
                    d.st = ST_AFTER;
                end
            end
            ST_AFTER: begin
                d.st = ST_LINK;
                if (q.ctx) begin
                    if (exec_ok && td_depth) begin
                        d.link = q.td_link;
                    end else begin
                        d.link = q.qh_horiz;
                        d.ctx  = 1'b0;
                    end
                end else begin
                    d.link = q.td_link;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    // port drive from registered state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.st)
            ST_RD_FL: begin
                mem_req  = 1'b1;
                mem_addr = q.fl_addr;
            end
            ST_RD_QH0: begin
                mem_req  = 1'b1;
                mem_addr = q.qh_addr;
            end
            ST_RD_QH1: begin
                mem_req  = 1'b1;
                mem_addr = q.qh_addr + WORD_OFS;
            end
            ST_RD_TD0: begin
                mem_req  = 1'b1;
                mem_addr = q.td_addr;
            end
            ST_RD_TD1: begin
                mem_req  = 1'b1;
                mem_addr = q.td_addr + WORD_OFS;
            end
            ST_WR_TD: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.td_addr + WORD_OFS;
                mem_wdata = merged_word;
            end
            ST_WR_QH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.qh_addr + WORD_OFS;
                mem_wdata = q.td_link;
            end
            default: ;
        endcase
    end

    assign exec_req     = (q.st == ST_EXEC);
    assign exec_td_addr = q.td_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
    parameter int W    = 32,
    parameter int FN_W = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_ack,
    input logic            mem_we,
    input logic [W-1:0]    mem_addr,
    input logic [W-1:0]    mem_wdata,
    input logic            exec_req,
    input logic            exec_done,
    input logic [W-1:0]    exec_td_addr,
    input logic [FN_W-1:0] frame_num
);
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

    AST_EXEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_req && !exec_done) |=> (exec_req && $stable(exec_td_addr))); // R12

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && exec_req)); // R12

    AST_FN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_num != $past(frame_num)) |-> (frame_num == $past(frame_num) + FN_W'(1))); // R2
endmodule

bind sched_walker sw_checker #(.W(W), .FN_W(FN_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_ack      (mem_ack),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .exec_req     (exec_req),
    .exec_done    (exec_done),
    .exec_td_addr (exec_td_addr),
    .frame_num    (frame_num)
);

// File: tb/sched_walker_tb_top.sv
`timescale 1ns/1ps
module sched_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_tick = 1'b0;
    logic [31:0] list_base = 32'h0000_1000;
    logic [10:0] frame_num;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        exec_req;
    logic [31:0] exec_td_addr;
    logic        exec_done;
    logic [3:0]  exec_flags;
    logic [10:0] exec_len;

    int n_chk = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    sched_walker dut_i (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .list_base(list_base),
        .frame_num(frame_num), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .exec_req(exec_req), .exec_td_addr(exec_td_addr), .exec_done(exec_done),
        .exec_flags(exec_flags), .exec_len(exec_len)
    );

    // memory model
    logic [31:0] mem [0:2047];
    logic        poke_en = 1'b0;
    logic [31:0] poke_a = '0, poke_d = '0;
    logic        log_clr = 1'b0;
    int          acc_cnt;
    logic        rd_seen;
    logic [31:0] rd_first;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 32'h1;
            mem_ack  <= 1'b0;
            mem_rdata <= '0;
            acc_cnt  <= 0;
            rd_seen  <= 1'b0;
            rd_first <= '0;
        end else begin
            if (poke_en) mem[poke_a[12:2]] <= poke_d;
            if (log_clr) begin
                acc_cnt <= 0;
                rd_seen <= 1'b0;
            end
            if (mem_req && !mem_ack) begin
                mem_ack <= 1'b1;
                if (!log_clr) acc_cnt <= acc_cnt + 1;
                if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
                else begin
                    mem_rdata <= mem[mem_addr[12:2]];
                    if (!rd_seen || log_clr) begin
                        rd_seen  <= 1'b1;
                        rd_first <= mem_addr;
                    end
                end
            end else begin
                mem_ack <= 1'b0;
            end
        end
    end

    // executor model
    logic [3:0]  resp_flags [0:255];
    logic [10:0] resp_len   [0:255];
    int          exec_delay = 1;
    int          wcnt;
    logic [31:0] seq;
    int          exec_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            exec_done  <= 1'b0;
            exec_flags <= '0;
            exec_len   <= '0;
            wcnt       <= 0;
            seq        <= '0;
            exec_cnt   <= 0;
        end else begin
            if (log_clr) begin
                seq      <= '0;
                exec_cnt <= 0;
            end
            if (exec_req && !exec_done) begin
                if (wcnt >= exec_delay) begin
                    exec_done  <= 1'b1;
                    wcnt       <= 0;
                    exec_flags <= resp_flags[exec_td_addr[11:4]];
                    exec_len   <= resp_len[exec_td_addr[11:4]];
                    seq        <= (seq << 8) | {24'b0, exec_td_addr[11:4]};
                    exec_cnt   <= exec_cnt + 1;
                end else begin
                    wcnt <= wcnt + 1;
                end
            end else begin
                exec_done <= 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] v);
        @(negedge clk);
        poke_en = 1'b1; poke_a = a; poke_d = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem[a[12:2]];
    endfunction

    task automatic clear_logs();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    // set the entry of the next frame, tick, wait, check frame index handling
    task automatic run_walk(input logic [31:0] entry, input int waitc);
        logic [10:0] fn0;
        fn0 = frame_num;
        poke(32'h1000 + {20'b0, fn0[9:0], 2'b00}, entry);
        clear_logs();
        pulse_tick();
        repeat (waitc) @(negedge clk);
        check("R2 frame_num step", {21'b0, frame_num}, {21'b0, fn0 + 11'd1});
        check("R2 first read addr", rd_first, 32'h1000 + {20'b0, fn0[9:0], 2'b00});
    endtask

    typedef struct packed {
        logic        depth;
        logic        live;
        logic [3:0]  flags;
        logic [10:0] len;
        logic [31:0] seq;
        logic [31:0] elem;
        logic [31:0] aw2;
    } row_t;

    // flags order {stall, nak, crc, stuff}; ids: A=0x20, B=0x24, C=0x30
    localparam row_t ROWS [7] = '{
        '{1'b0, 1'b1, 4'b0000, 11'h040, 32'h0000_2030,  32'h0000_0240, 32'h0400_0040},
        '{1'b1, 1'b1, 4'b0000, 11'h008, 32'h0020_2430,  32'h0000_0001, 32'h0400_0008},
        '{1'b1, 1'b1, 4'b0100, 11'h000, 32'h0000_2030,  32'h0000_0200, 32'h0408_0000},
        '{1'b0, 1'b1, 4'b0010, 11'h003, 32'h0000_2030,  32'h0000_0200, 32'h0404_0003},
        '{1'b0, 1'b0, 4'b0000, 11'h000, 32'h0000_0030,  32'h0000_0200, 32'h0400_0000},
        '{1'b1, 1'b1, 4'b1000, 11'h7FF, 32'h0000_2030,  32'h0000_0200, 32'h0440_07FF},
        '{1'b1, 1'b1, 4'b0001, 11'h005, 32'h0000_2030,  32'h0000_0200, 32'h0402_0005}
    };

    initial begin
        for (int i = 0; i < 256; i++) begin
            resp_flags[i] = '0;
            resp_len[i]   = '0;
        end
        repeat (4) @(negedge clk);
        // R1 during reset
        check("R1 fn in reset", {21'b0, frame_num}, 32'h0);
        check("R1 mem_req in reset", {31'b0, mem_req}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 idle after reset", {30'b0, mem_req, exec_req}, 32'h0);
        check("R1 fn after reset", {21'b0, frame_num}, 32'h0);

        // table of queue scenarios: R3 R5 R6 R7 R8
        for (int r = 0; r < 7; r++) begin
            poke(32'h100, 32'h0000_0300);
            poke(32'h104, 32'h0000_0200);
            poke(32'h200, 32'h0000_0240 | {29'b0, ROWS[r].depth, 2'b00});
            poke(32'h204, 32'h0400_0000 | {8'b0, ROWS[r].live, 23'b0});
            poke(32'h240, 32'h0000_0001);
            poke(32'h244, 32'h0080_0000);
            poke(32'h300, 32'h0000_0001);
            poke(32'h304, 32'h0080_0000);
            resp_flags[8'h20] = ROWS[r].flags;
            resp_len[8'h20]   = ROWS[r].len;
            run_walk(32'h0000_0102, 300);
            check("R8 R3 exec order", seq, ROWS[r].seq);
            check("R7 member link", peek(32'h104), ROWS[r].elem);
            check("R6 R5 status word", peek(32'h204), ROWS[r].aw2);
        end
        resp_flags[8'h20] = '0;

        // R4 empty queue goes on to next-queue link
        poke(32'h104, 32'h0000_0001);
        poke(32'h304, 32'h0080_0000);
        run_walk(32'h0000_0102, 200);
        check("R4 empty queue order", seq, 32'h30);
        check("R4 R3 access count", acc_cnt, 6);

        // R9 record outside queue followed even on error
        poke(32'h300, 32'h0000_0340);
        poke(32'h304, 32'h0080_0000);
        poke(32'h340, 32'h0000_0001);
        poke(32'h344, 32'h0080_0000);
        resp_flags[8'h30] = 4'b0010;
        run_walk(32'h0000_0300, 200);
        check("R9 chain order", seq, 32'h3034);
        resp_flags[8'h30] = '0;

        // R10 tick during execution
        begin
            logic [10:0] fn0;
            poke(32'h304, 32'h0080_0000);
            poke(32'h344, 32'h0080_0000);
            resp_len[8'h30] = 11'h010;
            exec_delay = 40;
            fn0 = frame_num;
            poke(32'h1000 + {20'b0, fn0[9:0], 2'b00}, 32'h0000_0300);
            clear_logs();
            pulse_tick();
            repeat (20) @(negedge clk);
            pulse_tick();
            repeat (200) @(negedge clk);
            check("R10 next element not run", seq, 32'h30);
            check("R10 access count", acc_cnt, 5);
            check("R10 status kept written", peek(32'h304), 32'h0000_0010);
            check("R10 frame advance", {21'b0, frame_num}, {21'b0, fn0 + 11'd2});
            check("R12 single execution", exec_cnt, 1);
            exec_delay = 1;
        end

        // R11 self-looped record
        poke(32'h400, 32'h0000_0400);
        poke(32'h404, 32'h0080_0000);
        run_walk(32'h0000_0400, 600);
        check("R11 loop exec", seq, 32'h40);
        check("R11 loop access count", acc_cnt, 130);

        // R2 wrap of the frame counter
        for (int i = 0; i < 32; i++) poke(32'h1000 + i * 4, 32'h1);
        while (frame_num != 11'h7FF) begin
            pulse_tick();
            repeat (6) @(negedge clk);
        end
        check("R2 reached top", {21'b0, frame_num}, 32'h7FF);
        clear_logs();
        pulse_tick();
        repeat (10) @(negedge clk);
        check("R2 wrap to zero", {21'b0, frame_num}, 32'h0);
        check("R2 top entry addr", rd_first, 32'h0000_1FFC);
        check("R3 terminate entry ends walk", acc_cnt, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule